// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block is a three-channel, 16-bit down-counting interval timer. A CPU reaches it through a small byte-wide register bus. One control port sets up a channel: it picks the channel, stores that channel's counting mode, and sets how the 16-bit values are moved one byte at a time. Three data ports, one per channel, load and read back the programmed count values.

Counting is paced by a clock-enable input, `tick_en`. A channel whose mode is "interrupt on terminal count" counts down once and stops. A channel in rate-generator mode reloads itself and runs without end. Only channel 0 can raise the interrupt line. Any bus access acknowledges that interrupt. Settings the block does not support raise a sticky error flag.

Top module: `pit_timer`

## Requirements
- R1: Offsets 0, 1 and 2 are the data ports of channels 0, 1 and 2. Offset 3 is the control port. Any offset of 4 or above is unmapped: a read there returns 0 and any access there sets the error flag.
- R2: The control byte is laid out as follows. Bits 7:6 choose the channel, and the value 3 is treated as channel 0. Bits 3:1 hold the mode: 000 is terminal-count interrupt and 010 is rate generator. Bit 0 requests BCD counting. Bits 5:4 set the byte access: 01 is low byte only, 10 is high byte only, 11 is low byte then high byte. A control write stores the mode of the chosen channel, stops that channel, and returns the byte pointer to the low byte.
- R3: A read of the control port returns the last control byte written, or 0 after reset.
- R4: A data write aimed at the low byte replaces bits 7:0 of the programmed value and keeps bits 15:8. A data write aimed at the high byte replaces bits 15:8 and keeps bits 7:0.
- R5: A data read returns bits 7:0 of the programmed value when aimed at the low byte, and bits 15:8 when aimed at the high byte. `bus_rdata` is 0 in any cycle that is not a read. It is combinational with the bus inputs.
- R6: In low-then-high access, every data access, read or write, moves the shared byte pointer to the high byte. The pointer stays on the high byte until the next control write.
- R7: A data write completes a load in two cases: every write under a single-byte access, or the high-byte write under low-then-high access. A completed load sets the channel's count from the new programmed value, with 0 meaning 65536, and starts the channel.
- R8: When channel 0 is in terminal-count mode, `irq` rises at the clock edge that samples the Nth `tick_en` after a load of N. The channel then stops. No other channel drives `irq`.
- R9: A rate-generator channel reloads its programmed value when its count reaches one, and never raises `irq`. After reset all channels are in rate-generator mode, so ticks alone raise no interrupt.
- R10: Any cycle with `bus_sel` high clears a pending interrupt at the next edge. A terminal event in the same cycle takes priority, and `irq` is then set.
- R11: `err` is sticky until reset. It is set by any of these: a control byte with bit 0 set, an unsupported mode, or access bits 00; a data access while the stored access bits are 00, which has no other effect and reads 0; an unmapped offset. A channel holding an unsupported setting does not count.
- R12: After reset, `irq` and `err` are 0, the control byte is 0, and every programmed value is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable; each high cycle is one count step |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| irq | output | 1 | Channel 0 terminal-count interrupt |
| err | output | 1 | Sticky unsupported-access flag |

## Verification
Two cases are the hardest to reach. The first is a terminal event in the very cycle a bus access acknowledges the interrupt. The bench reaches it by loading a short count and placing a control-port read on exactly the tick that should fire. The second is the 65536 case, which is reached by loading zero and running 65535 ticks before the last one. The shared byte pointer is exercised by mixing reads and writes under low-then-high access. A behavioural model follows the pointer, the counts and the flags cycle by cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_e;

  localparam logic [2:0] MODE_TC   = 3'b000;
  localparam logic [2:0] MODE_RATE = 3'b010;

  typedef struct packed {
    logic [2:0] mode;
    logic       bcd;
  } chcfg_t;

  // 0 stands for the full 2^CNT_W period
  function automatic logic [CNT_W:0] start_count(input logic [CNT_W-1:0] v);
    start_count = (v == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, v};
  endfunction

  function automatic logic [CNT_W-1:0] put_byte(input logic [CNT_W-1:0] old,
                                                input logic [7:0] b, input logic hi);
    put_byte = hi ? {b, old[7:0]} : {old[CNT_W-1:8], b};
  endfunction

  function automatic logic [7:0] get_byte(input logic [CNT_W-1:0] v, input logic hi);
    get_byte = hi ? v[CNT_W-1:8] : v[7:0];
  endfunction

  function automatic logic cfg_runs(input chcfg_t c);
    cfg_runs = !c.bcd && (c.mode == MODE_TC || c.mode == MODE_RATE);
  endfunction

  function automatic logic ctrl_bad(input logic [7:0] b);
    ctrl_bad = b[0] || !(b[3:1] == MODE_TC || b[3:1] == MODE_RATE) || (b[5:4] == 2'b00);
  endfunction
endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode
  import pit_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int N_CH   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [7:0]                  bus_wdata,
  input  logic [N_CH-1:0][CNT_W-1:0]  reload_vals,
  output logic [7:0]                  bus_rdata,
  output logic [N_CH-1:0]             cfg_we,
  output logic [N_CH-1:0]             wr_lo,
  output logic [N_CH-1:0]             wr_hi,
  output logic [N_CH-1:0]             load_done,
  output logic                        err
);
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [7:0] ctrl_q;
  logic       hi_ptr_q;
  logic       err_q;

  logic            is_ctrl, is_data, is_unmapped;
  acc_e            acc_type;
  logic            type_bad, byte_hi, data_ok, err_set;
  logic [CH_W-1:0] ch_idx, ctrl_tgt;

  assign is_ctrl     = bus_sel && (bus_addr == ADDR_W'(N_CH));
  assign is_data     = bus_sel && (bus_addr <  ADDR_W'(N_CH));
  assign is_unmapped = bus_sel && (bus_addr >  ADDR_W'(N_CH));
  assign acc_type    = acc_e'(ctrl_q[5:4]);
  assign type_bad    = (acc_type == ACC_NONE);
  assign byte_hi     = (acc_type == ACC_HI) || (acc_type == ACC_LOHI && hi_ptr_q);
  assign data_ok     = is_data && !type_bad;
  assign ch_idx      = bus_addr[CH_W-1:0];
  assign ctrl_tgt    = (int'(bus_wdata[7:6]) < N_CH) ? CH_W'(bus_wdata[7:6]) : '0;
  assign err_set     = is_unmapped || (is_data && type_bad) ||
                       (is_ctrl && bus_we && ctrl_bad(bus_wdata));

  for (genvar i = 0; i < N_CH; i++) begin : g_strobe
    logic hit;
    assign hit          = data_ok && bus_we && (ch_idx == CH_W'(i));
    assign cfg_we[i]    = is_ctrl && bus_we && (ctrl_tgt == CH_W'(i));
    assign wr_lo[i]     = hit && !byte_hi;
    assign wr_hi[i]     = hit && byte_hi;
    assign load_done[i] = hit && (acc_type != ACC_LOHI || hi_ptr_q);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (is_ctrl)      bus_rdata = ctrl_q;
      else if (data_ok) bus_rdata = get_byte(reload_vals[ch_idx], byte_hi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      hi_ptr_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (is_ctrl && bus_we) begin
        ctrl_q   <= bus_wdata;
        hi_ptr_q <= 1'b0;
      end else if (data_ok && acc_type == ACC_LOHI) begin
        hi_ptr_q <= 1'b1;
      end
      if (err_set) err_q <= 1'b1;
    end
  end

  assign err = err_q;

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) !$fell(err_q));
  // R6
  lohi_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_ptr_q) |-> $past(acc_type == ACC_LOHI));
  // R2
  cfg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cfg_we));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter bit RAISES_IRQ = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cfg_we,
  input  chcfg_t           cfg_in,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             load_done,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] reload_val,
  output logic             term
);
  chcfg_t           cfg_q;
  logic [CNT_W-1:0] reload_q, reload_nxt;
  logic [CNT_W:0]   cnt_q;
  logic             armed_q;

  logic runs, at_one, step, is_tc;

  assign runs   = armed_q && cfg_runs(cfg_q);
  assign at_one = (cnt_q == (CNT_W+1)'(1));
  assign step   = tick_en && runs;
  assign is_tc  = (cfg_q.mode == MODE_TC);
  assign term   = RAISES_IRQ ? (step && at_one && is_tc) : 1'b0;

  always_comb begin
    reload_nxt = reload_q;
    if (wr_lo)      reload_nxt = put_byte(reload_q, wdata, 1'b0);
    else if (wr_hi) reload_nxt = put_byte(reload_q, wdata, 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '{mode: MODE_RATE, bcd: 1'b0};
      reload_q <= '0;
      cnt_q    <= '0;
      armed_q  <= 1'b0;
    end else begin
      reload_q <= reload_nxt;
      if (cfg_we) begin
        cfg_q   <= cfg_in;
        armed_q <= 1'b0;
      end else if (load_done) begin
        cnt_q   <= start_count(reload_nxt);
        armed_q <= 1'b1;
      end else if (step) begin
        if (at_one) begin
          if (is_tc) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
          end else begin
            cnt_q <= start_count(reload_q);
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign reload_val = reload_q;

  // R9
  rate_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cfg_q.mode == MODE_RATE) |-> (cnt_q != '0));
  // R7
  load_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && !cfg_we) |=> (armed_q && cnt_q != '0));
  // R8
  term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !load_done && !cfg_we) |=> !armed_q);
  // R11
  bad_cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_runs(cfg_q) && !load_done && !cfg_we) |=> $stable(cnt_q));
endmodule

// File: rtl/pit_irq.sv
module pit_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_sel,
  input  logic term_any,
  output logic irq
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (term_any) irq_q <= 1'b1;
    else if (bus_sel)  irq_q <= 1'b0;
  end

  assign irq = irq_q;

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !term_any) |=> !irq_q);
  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(term_any));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int N_CH   = 3,
  parameter int IRQ_CH = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              err
);
  logic [N_CH-1:0][CNT_W-1:0] reload_vals;
  logic [N_CH-1:0]            cfg_we, wr_lo, wr_hi, load_done, term_vec;
  chcfg_t                     cfg_in;

  assign cfg_in = '{mode: bus_wdata[3:1], bcd: bus_wdata[0]};

  pit_bus_decode #(.ADDR_W(ADDR_W), .N_CH(N_CH)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .reload_vals(reload_vals),
    .bus_rdata(bus_rdata), .cfg_we(cfg_we), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .load_done(load_done), .err(err)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    pit_channel #(.RAISES_IRQ(i == IRQ_CH)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_we(cfg_we[i]),
      .cfg_in(cfg_in), .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]),
      .load_done(load_done[i]), .wdata(bus_wdata),
      .reload_val(reload_vals[i]), .term(term_vec[i])
    );
  end

  pit_irq u_irq (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .term_any(|term_vec), .irq(irq)
  );
endmodule

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, tick_en, bus_sel, bus_we;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  wire  [7:0] bus_rdata;
  wire        irq, err;

  pit_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .err(err)
  );

  int checks = 0, errors = 0;
  int m_ctrl, m_hi, m_irq, m_err;
  int m_mode[3], m_bcd[3], m_rel[3], m_cnt[3], m_arm[3];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int startv(int v); return (v == 0) ? 65536 : v; endfunction
  function automatic int ch_runs(int c);
    return (m_bcd[c] == 0 && (m_mode[c] == 0 || m_mode[c] == 2)) ? 1 : 0;
  endfunction

  function automatic int exp_read(int a);
    int t = (m_ctrl >> 4) & 3;
    int hi;
    if (a == 3) return m_ctrl;
    if (a > 3 || t == 0) return 0;
    hi = (t == 2 || (t == 3 && m_hi == 1)) ? 1 : 0;
    return hi ? (m_rel[a] >> 8) & 255 : m_rel[a] & 255;
  endfunction

  task automatic model_reset();
    m_ctrl = 0; m_hi = 0; m_irq = 0; m_err = 0;
    for (int c = 0; c < 3; c++) begin
      m_mode[c] = 2; m_bcd[c] = 0; m_rel[c] = 0; m_cnt[c] = 0; m_arm[c] = 0;
    end
  endtask

  task automatic model_step(bit sel, bit we, int a, int d, bit tk);
    int t = (m_ctrl >> 4) & 3;
    int fire = 0;
    for (int c = 0; c < 3; c++) begin
      if (tk && m_arm[c] == 1 && ch_runs(c) == 1) begin
        if (m_cnt[c] == 1) begin
          if (m_mode[c] == 0) begin
            m_arm[c] = 0; m_cnt[c] = 0;
            if (c == 0) fire = 1;
          end else m_cnt[c] = startv(m_rel[c]);
        end else m_cnt[c]--;
      end
    end
    if (sel) m_irq = 0;
    if (fire == 1) m_irq = 1;
    if (sel) begin
      if (a == 3) begin
        if (we) begin
          int ch = (d >> 6) & 3;
          int md = (d >> 1) & 7;
          if (ch == 3) ch = 0;
          m_ctrl = d; m_mode[ch] = md; m_bcd[ch] = d & 1; m_arm[ch] = 0; m_hi = 0;
          if ((d & 1) == 1 || !(md == 0 || md == 2) || ((d >> 4) & 3) == 0) m_err = 1;
        end
      end else if (a < 3) begin
        if (t == 0) m_err = 1;
        else begin
          int hi = (t == 2 || (t == 3 && m_hi == 1)) ? 1 : 0;
          if (we) begin
            if (hi == 1) m_rel[a] = (m_rel[a] & 255) | (d << 8);
            else         m_rel[a] = (m_rel[a] & 'hff00) | d;
            if (t != 3 || m_hi == 1) begin
              m_cnt[a] = startv(m_rel[a]); m_arm[a] = 1;
            end
          end
          if (t == 3) m_hi = 1;
        end
      end else m_err = 1;
    end
  endtask

  task automatic step(bit sel, bit we, int a, int d, bit tk, output int rd);
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = a[3:0]; bus_wdata = d[7:0]; tick_en = tk;
    #1;
    check("R8 irq vs model", int'(irq), m_irq);
    check("R11 err vs model", int'(err), m_err);
    check("R5 rdata vs model", int'(bus_rdata), (sel && !we) ? exp_read(a) : 0);
    rd = int'(bus_rdata);
    @(posedge clk);
    model_step(sel, we, a, d, tk);
  endtask

  task automatic wr(int a, int d);
    int rd;
    step(1'b1, 1'b1, a, d, 1'b0, rd);
  endtask

  task automatic rd_expect(int a, int exp, string tag);
    int rd;
    step(1'b1, 1'b0, a, 0, 1'b0, rd);
    check(tag, rd, exp);
  endtask

  task automatic idle(int n, bit tk);
    int rd;
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 0, 0, tk, rd);
  endtask

  task automatic observe(string tag, int act_sel, int exp);
    #1;
    check(tag, act_sel == 0 ? int'(irq) : int'(err), exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; tick_en = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int rd;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; tick_en = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    model_reset();
    do_reset();
    observe("R12 irq after reset", 0, 0);
    observe("R12 err after reset", 1, 0);
    rd_expect(3, 0, "R3 ctrl after reset");
    idle(20, 1'b1);
    observe("R9 reset rate mode no irq", 0, 0);

    // channel 0 terminal count, value 5, low then high
    wr(3, 'h30); wr(0, 5); wr(0, 0);
    idle(4, 1'b1);
    observe("R8 no irq before Nth tick", 0, 0);
    idle(1, 1'b1);
    observe("R8 irq on Nth tick", 0, 1);
    idle(3, 1'b1);
    observe("R8 irq held after stop", 0, 1);
    rd_expect(3, 'h30, "R3 ctrl readback");
    observe("R10 access clears irq", 0, 0);

    // pointer behaviour and byte reads
    wr(3, 'h30);
    rd_expect(0, 5, "R6 first read low");
    rd_expect(0, 0, "R6 second read high");
    rd_expect(0, 0, "R6 pointer stays high");
    wr(3, 'h20); wr(0, 'h12);
    rd_expect(0, 'h12, "R4 high write keeps low");
    wr(3, 'h10); wr(0, 'h03);
    rd_expect(0, 'h03, "R4 low write");
    wr(3, 'h20);
    rd_expect(0, 'h12, "R4 high kept after low write");
    wr(0, 'h00);
    idle(2, 1'b1);
    observe("R7 single-byte load starts", 0, 0);
    idle(1, 1'b1);
    observe("R7 single-byte load fires", 0, 1);

    // channel select 3 folds to channel 0
    wr(3, 'hF0);
    observe("R10 write clears irq", 0, 0);
    wr(0, 2); wr(0, 0);
    idle(2, 1'b1);
    observe("R2 select 3 targets channel 0", 0, 1);
    rd_expect(3, 'hF0, "R3 ctrl F0 readback");

    // terminal event coincides with acknowledge
    wr(3, 'h30); wr(0, 3); wr(0, 0);
    idle(2, 1'b1);
    step(1'b1, 1'b0, 3, 0, 1'b1, rd);
    observe("R10 terminal beats acknowledge", 0, 1);
    rd_expect(3, 'h30, "R3 ctrl again");

    // rate generators never interrupt
    wr(3, 'h74); wr(1, 3); wr(1, 0);
    wr(3, 'h34); wr(0, 2); wr(0, 0);
    idle(30, 1'b1);
    observe("R9 rate generator no irq", 0, 0);

    // channel 2 data port and no irq from it
    wr(3, 'hB0); wr(2, 'h34); wr(2, 'h12);
    wr(3, 'hB0);
    rd_expect(2, 'h34, "R1 channel 2 low byte");
    rd_expect(2, 'h12, "R1 channel 2 high byte");
    wr(3, 'hB0); wr(2, 4); wr(2, 0);
    idle(10, 1'b1);
    observe("R8 channel 2 raises no irq", 0, 0);

    // zero means 65536
    wr(3, 'h30); wr(0, 0); wr(0, 0);
    idle(65535, 1'b1);
    observe("R7 zero count not yet", 0, 0);
    idle(1, 1'b1);
    observe("R7 zero count is 65536", 0, 1);
    observe("R11 no error on legal use", 1, 0);

    // error cases
    rd_expect(5, 0, "R1 unmapped read zero");
    observe("R1 unmapped sets err", 1, 1);
    idle(3, 1'b0);
    observe("R11 err sticky", 1, 1);

    do_reset();
    rd_expect(0, 0, "R11 type 00 data read zero");
    observe("R11 type 00 data access err", 1, 1);

    do_reset();
    wr(3, 'h31); wr(0, 2); wr(0, 0);
    observe("R11 BCD sets err", 1, 1);
    idle(5, 1'b1);
    observe("R11 BCD channel does not count", 0, 0);

    do_reset();
    wr(3, 'h36);
    observe("R11 unsupported mode err", 1, 1);

    do_reset();
    wr(9, 'h55);
    observe("R1 unmapped write err", 1, 1);

    finish_run();
  end
endmodule